// File: doc/BRIEF.md
# Sticky Security Configuration Register Bank

This block is a small byte-addressed register bank on a CPU-side bus with write strobe, read strobe, address, write data and registered read data. It holds the controls that fix a chip's security posture during boot. There are one-way protection flags that close the main processor's upper boot ROM window, the one-time-programmable area and the secondary processor's boot ROM. A one-way release lets the secondary processor out of reset. There are per-requester DMA enables and a boot-environment code that survives a soft reset. Its outputs are the levels that the rest of the chip uses to gate those resources.

The reset release of the secondary processor is a two-state machine. It starts in `REL_HELD`, where the hold output is high. It takes the transition `REL_HELD -> REL_RUNNING` when a write to the reset-control register carries bit 0 = 0. `REL_RUNNING` has only a self-loop, so only a reset brings the machine back to `REL_HELD`. The protection flags use set-only storage cells, which a write can raise but never lower. Two reset inputs exist. A cold reset clears everything. A soft reset clears everything except the boot-environment code.

Top module: `cfg_sec_bank`

## Requirements
- R1: After a cold reset the protection outputs are 0, `sec_cpu_hold` is 1, `boot_env` is 0, and reads of offsets 0x00, 0x01, 0x08, 0x10000 and 0x10014 return 0. A read of offset 0x02 returns 1.
- R2: Offset 0x00 implements bit 0 (drives `main_rom_off`) and bit 1 (drives `otp_off`). Writing 1 to a bit sets it, writing 0 leaves it set, and bits 31..2 read 0.
- R3: Offset 0x01 implements only bit 0, which drives `sub_rom_off`. It is set-only in the same way, and bits 31..1 read 0.
- R4: Offset 0x02 bit 0 is the secondary processor hold, with reset value 1. Writing 0 clears it (`REL_HELD -> REL_RUNNING`), and no later write sets it again before a reset.
- R5: Offset 0x08 bits 3..0 are read/write enables for DMA requesters 2, 3, 4 and 5 in that order, shown on `dma_en[5:2]`. Bits 31..4 read 0.
- R6: `dma_en` bits 0, 1, 6, 7 and 8 are always 1, whatever has been written.
- R7: Offset 0x10000 holds an 8-bit boot-environment code, shown on `boot_env`. Only a cold reset clears it, and it keeps its value through a soft reset. Upper read bits are 0.
- R8: Offset 0x10010 reads `unit_info` and ignores writes. Offset 0x10014 is an 8-bit read/write register that holds a copy of it.
- R9: A soft reset returns every register and output except the boot-environment code to its R1 value, including the set-only flags and the released hold.
- R10: Reads of unmapped offsets return 0, and writes to them change no register.
- R11: `rdata` shows the addressed value in the cycle after `rd_en`, taken before any write in the same cycle. It is 0 in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Synchronous cold reset, active low, clears all state |
| soft_rst_n | input | 1 | Synchronous soft reset, active low, keeps boot-environment code |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 17 | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| unit_info | input | 8 | Unit type value, zero on retail units |
| main_rom_off | output | 1 | Closes main processor boot ROM upper window |
| otp_off | output | 1 | Closes OTP area |
| sub_rom_off | output | 1 | Closes secondary processor boot ROM |
| sec_cpu_hold | output | 1 | Holds secondary processor in reset |
| dma_en | output | 9 | Enable per DMA requester ID |
| boot_env | output | 8 | Boot-environment code |

## Verification
A read and a write can land on the same register in the same cycle. The bench raises both strobes together on the unit-copy register and checks that `rdata` returns the old value, and that a following read returns the new one. A soft reset can also arrive with a stored boot-environment code while every set-only flag and the released hold are active. The bench then checks that the code is unchanged and that everything else is back at reset values.

// File: rtl/cfg_sec_pkg.sv
package cfg_sec_pkg;

    localparam int NUM_REGS     = 7;
    localparam int IX_PROT_MAIN = 0;
    localparam int IX_PROT_SUB  = 1;
    localparam int IX_SUB_RST   = 2;
    localparam int IX_DMA       = 3;
    localparam int IX_ENV       = 4;
    localparam int IX_UNIT      = 5;
    localparam int IX_UNIT_COPY = 6;

    typedef enum logic {
        REL_HELD    = 1'b0,
        REL_RUNNING = 1'b1
    } rel_state_e;

    function automatic logic [31:0] reg_offset(input int idx);
        case (idx)
            IX_PROT_MAIN: return 32'h0000_0000;
            IX_PROT_SUB:  return 32'h0000_0001;
            IX_SUB_RST:   return 32'h0000_0002;
            IX_DMA:       return 32'h0000_0008;
            IX_ENV:       return 32'h0001_0000;
            IX_UNIT:      return 32'h0001_0010;
            IX_UNIT_COPY: return 32'h0001_0014;
            default:      return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfg_sec_decode.sv
module cfg_sec_decode
    import cfg_sec_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int NREG   = NUM_REGS
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   sel,
    output logic              miss
);

    for (genvar g = 0; g < NREG; g++) begin : g_hit
        localparam logic [31:0] OFF = reg_offset(g);
        assign sel[g] = (addr == OFF[ADDR_W-1:0]);
    end

    assign miss = ~|sel;

endmodule

// File: rtl/cfg_sec_sticky.sv
module cfg_sec_sticky #(
    parameter int             W        = 2,
    parameter logic [W-1:0]   RST_VAL  = '0,
    parameter bit             SET_ONLY = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wbits,
    output logic [W-1:0] q
);

    if (SET_ONLY) begin : g_set_only
        always_ff @(posedge clk) begin
            if (!rst_n)  q <= RST_VAL;
            else if (we) q <= q | wbits;
        end

        AST_STICKY_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (($past(q) & ~q) == '0)); // R2
    end else begin : g_clear_only
        always_ff @(posedge clk) begin
            if (!rst_n)  q <= RST_VAL;
            else if (we) q <= q & wbits;
        end

        AST_STICKY_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> ((~$past(q) & q) == '0)); // R4
    end

endmodule

// File: rtl/cfg_sec_release.sv
module cfg_sec_release
    import cfg_sec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic wbit0,
    output logic hold
);

    rel_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= REL_HELD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REL_HELD:    if (we && !wbit0) state_d = REL_RUNNING;
            REL_RUNNING: state_d = REL_RUNNING;
            default:     state_d = REL_HELD;
        endcase
    end

    always_comb begin
        hold = (state_q == REL_HELD);
    end

    AST_HOLD_NO_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(hold)) |-> !hold); // R4

endmodule

// File: rtl/cfg_sec_bank.sv
module cfg_sec_bank
    import cfg_sec_pkg::*;
#(
    parameter int             ADDR_W     = 17,
    parameter int             DATA_W     = 32,
    parameter int             ENV_W      = 8,
    parameter int             UNIT_W     = 8,
    parameter int             DMA_IDS    = 9,
    parameter int             DMA_FIRST  = 2,
    parameter int             DMA_PROG_N = 4,
    parameter logic [8:0]     DMA_FORCED = 9'h1C3
) (
    input  logic               clk,
    input  logic               cold_rst_n,
    input  logic               soft_rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic [UNIT_W-1:0]  unit_info,
    output logic               main_rom_off,
    output logic               otp_off,
    output logic               sub_rom_off,
    output logic               sec_cpu_hold,
    output logic [DMA_IDS-1:0] dma_en,
    output logic [ENV_W-1:0]   boot_env
);

    localparam int DMA_LAST = DMA_FIRST + DMA_PROG_N - 1;

    logic                  rst_n;
    logic                  wr_ok;
    logic [NUM_REGS-1:0]   sel;
    logic                  miss;
    logic [1:0]            prot_main_q;
    logic [0:0]            prot_sub_q;
    logic [DMA_PROG_N-1:0] dma_q;
    logic [ENV_W-1:0]      env_q;
    logic [UNIT_W-1:0]     ucopy_q;
    logic [DATA_W-1:0]     rd_word;
    logic [DATA_W-1:0]     rdata_q;
    logic                  unused_wdata;

    assign rst_n = cold_rst_n & soft_rst_n;
    assign wr_ok = wr_en & rst_n;
    assign unused_wdata = &{1'b0, wdata[DATA_W-1:ENV_W]};

    cfg_sec_decode #(.ADDR_W(ADDR_W), .NREG(NUM_REGS)) u_decode (
        .addr (addr),
        .sel  (sel),
        .miss (miss)
    );

    cfg_sec_sticky #(.W(2), .RST_VAL(2'b00), .SET_ONLY(1'b1)) u_prot_main (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok & sel[IX_PROT_MAIN]),
        .wbits (wdata[1:0]),
        .q     (prot_main_q)
    );

    cfg_sec_sticky #(.W(1), .RST_VAL(1'b0), .SET_ONLY(1'b1)) u_prot_sub (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok & sel[IX_PROT_SUB]),
        .wbits (wdata[0:0]),
        .q     (prot_sub_q)
    );

    cfg_sec_release u_release (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok & sel[IX_SUB_RST]),
        .wbit0 (wdata[0]),
        .hold  (sec_cpu_hold)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                    dma_q <= '0;
        else if (wr_ok && sel[IX_DMA]) dma_q <= wdata[DMA_PROG_N-1:0];
    end

    // Boot-environment code: only the cold reset clears it.
    always_ff @(posedge clk) begin
        if (!cold_rst_n)               env_q <= '0;
        else if (wr_ok && sel[IX_ENV]) env_q <= wdata[ENV_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          ucopy_q <= '0;
        else if (wr_ok && sel[IX_UNIT_COPY]) ucopy_q <= wdata[UNIT_W-1:0];
    end

    for (genvar id = 0; id < DMA_IDS; id++) begin : g_dma
        if (id >= DMA_FIRST && id <= DMA_LAST) begin : g_prog
            assign dma_en[id] = dma_q[id-DMA_FIRST];
        end else begin : g_fixed
            assign dma_en[id] = DMA_FORCED[id];
        end
    end

    always_comb begin
        rd_word = '0;
        if (sel[IX_PROT_MAIN]) rd_word[1:0]            = prot_main_q;
        if (sel[IX_PROT_SUB])  rd_word[0]              = prot_sub_q[0];
        if (sel[IX_SUB_RST])   rd_word[0]              = sec_cpu_hold;
        if (sel[IX_DMA])       rd_word[DMA_PROG_N-1:0] = dma_q;
        if (sel[IX_ENV])       rd_word[ENV_W-1:0]      = env_q;
        if (sel[IX_UNIT])      rd_word[UNIT_W-1:0]     = unit_info;
        if (sel[IX_UNIT_COPY]) rd_word[UNIT_W-1:0]     = ucopy_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_en)  rdata_q <= rd_word;
        else             rdata_q <= '0;
    end

    assign rdata        = rdata_q;
    assign main_rom_off = prot_main_q[0];
    assign otp_off      = prot_main_q[1];
    assign sub_rom_off  = prot_sub_q[0];
    assign boot_env     = env_q;

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_en) && $past(miss)) |-> (rdata == '0)); // R10

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd_en)) |-> (rdata == '0)); // R11

    AST_ENV_KEPT_SOFT: assert property (@(posedge clk) disable iff (!cold_rst_n)
        ($past(cold_rst_n) && !$past(soft_rst_n)) |-> $stable(boot_env)); // R7

    AST_DMA_PROG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(sel[IX_DMA]))
        |-> (dma_en[DMA_LAST:DMA_FIRST] == $past(wdata[DMA_PROG_N-1:0]))); // R5

endmodule

// File: tb/cfg_sec_bank_bench.sv
`timescale 1ns/1ps
module cfg_sec_bank_bench;

    logic        clk = 1'b0;
    logic        cold_rst_n = 1'b0;
    logic        soft_rst_n = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [16:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  unit_info = 8'h5A;
    logic        main_rom_off, otp_off, sub_rom_off, sec_cpu_hold;
    logic [8:0]  dma_en;
    logic [7:0]  boot_env;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    cfg_sec_bank u_cfg_sec_bank (
        .clk          (clk),
        .cold_rst_n   (cold_rst_n),
        .soft_rst_n   (soft_rst_n),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .addr         (addr),
        .wdata        (wdata),
        .rdata        (rdata),
        .unit_info    (unit_info),
        .main_rom_off (main_rom_off),
        .otp_off      (otp_off),
        .sub_rom_off  (sub_rom_off),
        .sec_cpu_hold (sec_cpu_hold),
        .dma_en       (dma_en),
        .boot_env     (boot_env)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [16:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [16:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic pulse_cold();
        @(negedge clk);
        cold_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        cold_rst_n = 1'b1;
    endtask

    task automatic pulse_soft();
        @(negedge clk);
        soft_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        soft_rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        pulse_cold();
        chk("R1 main_rom_off", {31'b0, main_rom_off}, 32'd0);
        chk("R1 otp_off", {31'b0, otp_off}, 32'd0);
        chk("R1 sub_rom_off", {31'b0, sub_rom_off}, 32'd0);
        chk("R1 sec_cpu_hold", {31'b0, sec_cpu_hold}, 32'd1);
        chk("R1 boot_env", {24'b0, boot_env}, 32'd0);
        chk("R6 dma_en after reset", {23'b0, dma_en}, 32'h1C3);
        rd(17'h00000, v); chk("R1 read 0x00", v, 32'd0);
        rd(17'h00001, v); chk("R1 read 0x01", v, 32'd0);
        rd(17'h00002, v); chk("R1 read 0x02", v, 32'd1);
        rd(17'h00008, v); chk("R1 read 0x08", v, 32'd0);
        rd(17'h10000, v); chk("R1 read 0x10000", v, 32'd0);
        rd(17'h10014, v); chk("R1 read 0x10014", v, 32'd0);
    endtask

    task automatic t_prot_main();
        logic [31:0] v;
        wr(17'h00000, 32'h2);
        chk("R2 otp_off set alone", {31'b0, otp_off}, 32'd1);
        chk("R2 main_rom_off still clear", {31'b0, main_rom_off}, 32'd0);
        wr(17'h00000, 32'hFFFF_FFFF);
        rd(17'h00000, v); chk("R2 read both set, upper zero", v, 32'h3);
        wr(17'h00000, 32'h0);
        chk("R2 main_rom_off stays", {31'b0, main_rom_off}, 32'd1);
        chk("R2 otp_off stays", {31'b0, otp_off}, 32'd1);
        rd(17'h00000, v); chk("R2 read after zero write", v, 32'h3);
    endtask

    task automatic t_prot_sub();
        logic [31:0] v;
        wr(17'h00001, 32'hFFFF_FFFE);
        chk("R3 bit0 clear write leaves off", {31'b0, sub_rom_off}, 32'd0);
        rd(17'h00001, v); chk("R3 upper bits read zero", v, 32'd0);
        wr(17'h00001, 32'h1);
        chk("R3 sub_rom_off set", {31'b0, sub_rom_off}, 32'd1);
        wr(17'h00001, 32'h0);
        rd(17'h00001, v); chk("R3 stays set", v, 32'd1);
    endtask

    task automatic t_release();
        logic [31:0] v;
        wr(17'h00002, 32'h1);
        chk("R4 writing 1 keeps hold", {31'b0, sec_cpu_hold}, 32'd1);
        wr(17'h00002, 32'h0);
        chk("R4 writing 0 releases", {31'b0, sec_cpu_hold}, 32'd0);
        wr(17'h00002, 32'h1);
        chk("R4 no reassert", {31'b0, sec_cpu_hold}, 32'd0);
        rd(17'h00002, v); chk("R4 read released", v, 32'd0);
    endtask

    task automatic t_dma();
        logic [31:0] v;
        wr(17'h00008, 32'h5);
        chk("R5 dma 0x5", {23'b0, dma_en}, 32'h1D7);
        rd(17'h00008, v); chk("R5 read 0x5", v, 32'h5);
        wr(17'h00008, 32'hFFFF_FFF0);
        chk("R6 forced ids with zero enables", {23'b0, dma_en}, 32'h1C3);
        rd(17'h00008, v); chk("R5 reserved bits read zero", v, 32'h0);
        wr(17'h00008, 32'hF);
        chk("R5 all programmable enabled", {23'b0, dma_en}, 32'h1FF);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(17'h00004, 32'hFFFF_FFFF);
        wr(17'h10004, 32'hFFFF_FFFF);
        rd(17'h00004, v); chk("R10 read 0x04", v, 32'd0);
        rd(17'h10004, v); chk("R10 read 0x10004", v, 32'd0);
        rd(17'h00008, v); chk("R10 dma reg untouched", v, 32'hF);
        chk("R10 dma_en untouched", {23'b0, dma_en}, 32'h1FF);
        chk("R10 boot_env untouched", {24'b0, boot_env}, 32'd0);
    endtask

    task automatic t_unit();
        logic [31:0] v;
        rd(17'h10010, v); chk("R8 unit info read", v, 32'h5A);
        wr(17'h10010, 32'h0);
        rd(17'h10010, v); chk("R8 unit info ignores write", v, 32'h5A);
        wr(17'h10014, 32'h1A5);
        rd(17'h10014, v); chk("R8 unit copy read", v, 32'hA5);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 17'h10014; wdata = 32'h3C;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R11 same cycle read old", rdata, 32'hA5);
        @(negedge clk);
        chk("R11 idle rdata zero", rdata, 32'd0);
        rd(17'h10014, v); chk("R11 later read new", v, 32'h3C);
    endtask

    task automatic t_env();
        logic [31:0] v;
        wr(17'h10000, 32'hFFFF_FF07);
        chk("R7 boot_env written", {24'b0, boot_env}, 32'h07);
        rd(17'h10000, v); chk("R7 read env", v, 32'h07);
        pulse_soft();
        chk("R7 env kept by soft reset", {24'b0, boot_env}, 32'h07);
        chk("R9 main_rom_off cleared", {31'b0, main_rom_off}, 32'd0);
        chk("R9 otp_off cleared", {31'b0, otp_off}, 32'd0);
        chk("R9 sub_rom_off cleared", {31'b0, sub_rom_off}, 32'd0);
        chk("R9 hold reasserted", {31'b0, sec_cpu_hold}, 32'd1);
        chk("R9 dma cleared", {23'b0, dma_en}, 32'h1C3);
        rd(17'h10014, v); chk("R9 unit copy cleared", v, 32'd0);
        rd(17'h10000, v); chk("R7 env read after soft", v, 32'h07);
        pulse_cold();
        chk("R7 cold reset clears env", {24'b0, boot_env}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_prot_main();
        t_prot_sub();
        t_release();
        t_dma();
        t_unmapped();
        t_unit();
        t_same_cycle();
        t_env();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule